// File: doc/BRIEF.md
# Doorbell Interrupt Register File

This block is the register slave of an adapter that lets separate domains share a memory region and signal each other. It holds four 32-bit registers in a 256-byte window: an interrupt enable mask, an interrupt status register that clears itself when read, a read-only register reporting this endpoint's own peer position, and a write-only doorbell. Software rings a remote peer by writing a packed destination/vector word to the doorbell. The block checks that word against the current peer count and against that peer's vector count, which it reads from an external lookup. If both checks pass, it emits a one-cycle notify strobe carrying the pair.

A level interrupt output follows the masked status. A local-event input marks a pending interrupt in status. In message-signalled mode, or when the interrupt-pin configuration value is zero, the level output stays low and local events leave status untouched. The host bus is a simple valid/write request with 32-bit data. Read data comes back one cycle after the request.

Top module: `dbell_regfile`

## Requirements
- R1: After reset the mask and status registers are zero, the level interrupt is low and no notify strobe or read response is present.
- R2: The mask register sits at offset 0x0 and is readable and writable. Before decode, a write address has its two low bits forced to zero, so writes to offsets 0x1 to 0x3 reach the mask.
- R3: A read of the status register at offset 0x4 returns the value held before the read, and the read leaves status at zero. A write to 0x4 loads status with the write data.
- R4: The interrupt output is high exactly when (status AND mask) is nonzero, message-signalled mode is off and the interrupt-pin value is nonzero. In every other case it is low.
- R5: With message-signalled mode off, a local event sets status to exactly 1, replacing any previous value. With message-signalled mode on, a local event leaves status unchanged.
- R6: When a local event and a status write fall in the same cycle, the local event wins. The same holds when a local event coincides with a status read.
- R7: A read of offset 0x8 returns the own-position input, zero-extended. Writes to 0x8 change nothing.
- R8: A doorbell write to offset 0xC carries the destination peer in bits 31:16 and the vector in bits 7:0. The destination appears on the lookup port in the same cycle. In the cycle after an accepted write, the notify strobe is high for exactly one cycle and carries that peer and vector.
- R9: A doorbell write is dropped with no strobe when the destination is not below the peer count, or when the vector is not below the lookup's vector count for that destination.
- R10: A read of any offset other than exactly 0x0, 0x4 or 0x8 returns zero. This includes the doorbell and unaligned offsets. Writes to offsets outside the four registers change no state.
- R11: Every read request produces a read response one cycle later, and no response appears without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_mode | input | 1 | Message-signalled mode selected |
| irq_pin | input | PIN_W | Interrupt-pin configuration value; zero disables the level output |
| own_pos | input | PEER_W | This endpoint's peer position |
| peer_count | input | PEER_W+1 | Number of peers currently known |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset in the register window |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read response data |
| local_evt | input | 1 | Local interrupt event |
| lkp_peer | output | PEER_W | Peer whose vector count is being looked up |
| lkp_nvec | input | VEC_W+1 | Number of vectors registered for lkp_peer |
| ntf_valid | output | 1 | Notify strobe |
| ntf_peer | output | PEER_W | Notified peer |
| ntf_vec | output | VEC_W | Notified vector |
| irq | output | 1 | Level interrupt |

## Verification
The bench uses the default parameters: an 8-bit window address, 16-bit peer field and 8-bit vector field. These defaults keep the field positions exactly where the doorbell word defines them. The peer count is driven to small values, and the lookup answers the destination modulo 5. This makes the boundaries at count minus one and at count reachable in a few hundred random writes, along with peers that have zero vectors. Message-signalled mode and the pin value are toggled so that the interrupt gating and the ignored-event path are both exercised.

// File: rtl/dbell_regfile.sv
module dbell_regfile #(
  parameter int ADDR_W = 8,
  parameter int PEER_W = 16,
  parameter int VEC_W  = 8,
  parameter int PIN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msi_mode,
  input  logic [PIN_W-1:0]  irq_pin,
  input  logic [PEER_W-1:0] own_pos,
  input  logic [PEER_W:0]   peer_count,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  input  logic              local_evt,
  output logic [PEER_W-1:0] lkp_peer,
  input  logic [VEC_W:0]    lkp_nvec,
  output logic              ntf_valid,
  output logic [PEER_W-1:0] ntf_peer,
  output logic [VEC_W-1:0]  ntf_vec,
  output logic              irq
);

  localparam int PEER_LSB = 16;
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFF_POS  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFF_DB   = ADDR_W'(8'h0C);

  logic [31:0]       mask_q, stat_q;
  logic [ADDR_W-1:0] wr_off;
  logic              wr_en, rd_en, evt_set, db_ok;
  logic [PEER_W-1:0] db_peer;
  logic [VEC_W-1:0]  db_vec;
  logic [31:0]       rd_mux;

  assign wr_en   = req_valid & req_write;
  assign rd_en   = req_valid & ~req_write;
  assign wr_off  = {req_addr[ADDR_W-1:2], 2'b00};
  assign evt_set = local_evt & ~msi_mode;

  assign db_peer  = req_wdata[PEER_LSB +: PEER_W];
  assign db_vec   = req_wdata[VEC_W-1:0];
  assign lkp_peer = db_peer;
  assign db_ok    = wr_en && (wr_off == OFF_DB) &&
                    ({1'b0, db_peer} < peer_count) &&
                    ({1'b0, db_vec} < lkp_nvec);

  always_comb begin
    rd_mux = '0;
    if (req_addr == OFF_MASK)      rd_mux = mask_q;
    else if (req_addr == OFF_STAT) rd_mux = stat_q;
    else if (req_addr == OFF_POS)  rd_mux = 32'(own_pos);
  end

  assign irq = ~msi_mode && (irq_pin != '0) && ((stat_q & mask_q) != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q    <= '0;
      stat_q    <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      ntf_valid <= 1'b0;
      ntf_peer  <= '0;
      ntf_vec   <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
      if (wr_en && wr_off == OFF_MASK) mask_q <= req_wdata;
      if (evt_set)                                 stat_q <= 32'd1;
      else if (wr_en && wr_off == OFF_STAT)        stat_q <= req_wdata;
      else if (rd_en && req_addr == OFF_STAT)      stat_q <= '0;
      ntf_valid <= db_ok;
      if (db_ok) begin
        ntf_peer <= db_peer;
        ntf_vec  <= db_vec;
      end
    end
  end

  assert_clear_on_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && req_addr == OFF_STAT && !evt_set) |=> (stat_q == '0));

  assert_local_evt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_set |=> (stat_q == 32'd1));

  assert_msi_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_mode || stat_q == '0) |-> !irq);

  assert_strobe_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid |-> ($past(wr_en) && $past(wr_off) == OFF_DB));

  assert_drop_peer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_off == OFF_DB && {1'b0, db_peer} >= peer_count) |=> !ntf_valid);

  assert_rd_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

endmodule

// File: tb/test_dbell_regfile.sv
module test_dbell_regfile;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        msi_mode;
  logic [7:0]  irq_pin;
  logic [15:0] own_pos;
  logic [16:0] peer_count;
  logic        req_valid, req_write, local_evt;
  logic [7:0]  req_addr;
  logic [31:0] req_wdata;
  logic        rd_valid, ntf_valid, irq;
  logic [31:0] rd_data;
  logic [15:0] lkp_peer, ntf_peer;
  logic [8:0]  lkp_nvec;
  logic [7:0]  ntf_vec;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_mask, m_stat;

  always #2.5 clk = ~clk;

  function automatic logic [8:0] nvec_of(input logic [15:0] p);
    return 9'(p % 16'd5);
  endfunction
  assign lkp_nvec = nvec_of(lkp_peer);

  dbell_regfile i_dbell_regfile (
    .clk(clk), .rst_n(rst_n), .msi_mode(msi_mode), .irq_pin(irq_pin),
    .own_pos(own_pos), .peer_count(peer_count), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .local_evt(local_evt),
    .lkp_peer(lkp_peer), .lkp_nvec(lkp_nvec), .ntf_valid(ntf_valid),
    .ntf_peer(ntf_peer), .ntf_vec(ntf_vec), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit exp_irq();
    return !msi_mode && irq_pin != 0 && (m_stat & m_mask) != 0;
  endfunction

  task automatic step(input bit v, input bit w, input logic [7:0] a,
                      input logic [31:0] d, input bit e, input string req);
    logic [31:0] e_rd, n_mask, n_stat;
    logic [15:0] pp;
    logic [7:0]  vv;
    bit e_ntf;
    @(negedge clk);
    req_valid = v; req_write = w; req_addr = a; req_wdata = d; local_evt = e;
    n_mask = m_mask; n_stat = m_stat; e_rd = 0; e_ntf = 0;
    pp = d[31:16]; vv = d[7:0];
    if (v && !w) begin
      case (a)
        8'h00: e_rd = m_mask;
        8'h04: begin e_rd = m_stat; n_stat = 0; end
        8'h08: e_rd = {16'h0, own_pos};
        default: e_rd = 0;
      endcase
    end
    if (v && w) begin
      case (a & 8'hFC)
        8'h00: n_mask = d;
        8'h04: n_stat = d;
        8'h0C: e_ntf = ({1'b0, pp} < peer_count) && ({1'b0, vv} < nvec_of(pp));
        default: ;
      endcase
    end
    if (e && !msi_mode) n_stat = 32'd1;
    @(posedge clk); #1;
    m_mask = n_mask; m_stat = n_stat;
    check(rd_valid == (v && !w), {req, " R11 rd_valid"}, 32'(rd_valid), 32'(v && !w));
    if (v && !w) check(rd_data == e_rd, {req, " rd_data"}, rd_data, e_rd);
    check(ntf_valid == e_ntf, {req, " ntf_valid"}, 32'(ntf_valid), 32'(e_ntf));
    if (e_ntf) check(ntf_peer == pp && ntf_vec == vv, {req, " R8 ntf fields"},
                     {ntf_peer, 8'h0, ntf_vec}, {pp, 8'h0, vv});
    check(irq == exp_irq(), {req, " R4 irq"}, 32'(irq), 32'(exp_irq()));
  endtask

  task automatic rd(input logic [7:0] a, input string req);
    step(1, 0, a, 0, 0, req);
  endtask
  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string req);
    step(1, 1, a, d, 0, req);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] addrs [12] = '{8'h00, 8'h01, 8'h03, 8'h04, 8'h05, 8'h07,
                               8'h08, 8'h0A, 8'h0C, 8'h10, 8'hFC, 8'h40};
    void'($urandom(32'd7486));
    rst_n = 0; msi_mode = 0; irq_pin = 8'd1; own_pos = 16'h00A5; peer_count = 17'd6;
    req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0; local_evt = 0;
    m_mask = 0; m_stat = 0;
    repeat (3) @(posedge clk);
    #1;
    check(!irq && !ntf_valid && !rd_valid, "R1 outputs after reset", {irq, ntf_valid, rd_valid}, 0);
    @(negedge clk); rst_n = 1;
    rd(8'h00, "R1 mask reset");
    rd(8'h04, "R1 status reset");

    wr(8'h03, 32'h0000_00F0, "R2 mask via unaligned write");
    rd(8'h00, "R2 mask readback");
    wr(8'h04, 32'h0000_0030, "R3 status write");
    rd(8'h04, "R3 status read returns value");
    rd(8'h04, "R3 status cleared by read");
    wr(8'h04, 32'h0000_0011, "R5 preload status");
    step(0, 0, 0, 0, 1, "R5 event overwrites");
    rd(8'h04, "R5 status equals 1");
    step(1, 1, 8'h04, 32'hDEAD_0000, 1, "R6 event beats status write");
    rd(8'h04, "R6 status is 1");
    wr(8'h04, 32'h0000_0022, "R6 preload");
    step(1, 0, 8'h04, 0, 1, "R6 event beats clear-on-read");
    rd(8'h04, "R6 status after read+event");
    wr(8'h00, 32'h1, "R4 unmask bit0");
    wr(8'h04, 32'h1, "R4 irq high");
    @(negedge clk); irq_pin = 0;
    rd(8'h00, "R4 pin zero holds irq low");
    @(negedge clk); irq_pin = 8'd1; msi_mode = 1;
    rd(8'h00, "R4 msi holds irq low");
    wr(8'h04, 32'h0000_0044, "R5 msi preload");
    step(0, 0, 0, 0, 1, "R5 event ignored in msi");
    rd(8'h04, "R5 status unchanged in msi");
    @(negedge clk); msi_mode = 0;
    wr(8'h08, 32'hFFFF_FFFF, "R7 write own pos");
    rd(8'h08, "R7 own pos unchanged");
    wr(8'h10, 32'h1234_5678, "R10 unmapped write");
    wr(8'h40, 32'h1234_5678, "R10 unmapped write");
    rd(8'h00, "R10 mask unchanged");
    rd(8'h0C, "R10 doorbell reads zero");
    rd(8'h09, "R10 unaligned read zero");
    wr(8'h0C, {16'd4, 8'h0, 8'd3}, "R8 valid doorbell");
    wr(8'h0C, {16'd4, 8'h0, 8'd4}, "R9 vector at count dropped");
    wr(8'h0C, {16'd6, 8'h0, 8'd0}, "R9 peer at count dropped");
    wr(8'h0C, {16'd5, 8'h0, 8'd0}, "R9 zero-vector peer dropped");
    wr(8'h0D, {16'd1, 8'h0, 8'd0}, "R8 doorbell via unaligned");
    step(0, 0, 0, 0, 0, "R8 strobe lasts one cycle");

    for (int i = 0; i < 500; i++) begin
      logic [31:0] d;
      int k;
      k = $urandom_range(0, 11);
      d = $urandom();
      if ($urandom_range(0, 3) != 0) d[31:16] = 16'($urandom_range(0, 9));
      if ($urandom_range(0, 3) != 0) d[7:0] = 8'($urandom_range(0, 5));
      if (($urandom_range(0, 15)) == 0) begin
        @(negedge clk);
        msi_mode = 1'($urandom_range(0, 3) == 0);
        irq_pin = 8'($urandom_range(0, 2));
        peer_count = 17'($urandom_range(1, 9));
      end
      step(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)), addrs[k], d,
           1'($urandom_range(0, 7) == 0), "random");
    end
    step(0, 0, 0, 0, 0, "idle");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule